// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Aggregator

The block gathers level-sensitive interrupt requests into two processor interrupt lines. Two local groups of eight sources each have a status byte and a mask byte. Each group raises its own output while any unmasked status bit is set. A third group of eight mappable sources shares one status byte and has two independent mask bytes. Mask byte 0 folds the masked mappable sources into a reserved input of local group 0. Mask byte 1 does the same for a reserved input of local group 1.

Software reads and writes the registers over a byte-wide bus with an address, write data and a write strobe. Every external source passes through a two-flop synchroniser before it reaches a status register. Both interrupt outputs are registered.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset all four mask registers read 0x00 and both `irq0_o` and `irq1_o` are low.
- R2: Local status reads (address 0 for group 0, address 2 for group 1) return the source levels two clock edges after they are applied, with one exception: the reserved cascade slot, described in R7.
- R3: A mask register (address 1 for group 0, 3 for group 1, 5 for mappable mask 0, 6 for mappable mask 1) reads back the last byte written to it. Writes to the status addresses 0, 2 and 4 change no register.
- R4: `irq0_o` is high exactly when the group-0 status ANDed with the group-0 mask was nonzero one clock edge earlier.
- R5: `irq1_o` follows the same rule for group 1, using its own status and mask.
- R6: The mappable status read (address 4) returns all eight synchronised mappable sources, whatever the mappable masks hold.
- R7: Status bit 2 of group 0 equals the OR of (mappable status AND mappable mask 0). Status bit 3 of group 1 equals the OR of (mappable status AND mappable mask 1). The external local inputs at those two bit positions are ignored.
- R8: A read of address 7, which is unmapped, returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lcl0_src_i | input | 8 | Group-0 level sources, asynchronous |
| lcl1_src_i | input | 8 | Group-1 level sources, asynchronous |
| map_src_i | input | 8 | Mappable level sources, asynchronous |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational |
| irq0_o | output | 1 | Group-0 processor interrupt |
| irq1_o | output | 1 | Group-1 processor interrupt |

## Verification
The assertions assume that the sources are plain levels, held long enough for the synchroniser to capture them. They also assume that a write strobe lasts one cycle with a stable address and data. The bench changes sources and bus signals only on falling edges. It holds each source pattern for at least three rising edges before it compares status or interrupt outputs. It never drives a source for the same cycle as a mask write, so every expected value follows from a settled state.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int unsigned GRP_W  = 8;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_L0_STAT = 3'd0,
    ADR_L0_MASK = 3'd1,
    ADR_L1_STAT = 3'd2,
    ADR_L1_MASK = 3'd3,
    ADR_MP_STAT = 3'd4,
    ADR_MP_MSK0 = 3'd5,
    ADR_MP_MSK1 = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_local_group.sv
module irq_local_group #(
  parameter int unsigned W        = 8,
  parameter int unsigned CAS_SLOT = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_sync_i,
  input  logic         cas_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  // reserved slot carries the cascaded mappable request
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b == CAS_SLOT) begin : g_cas
      assign status_o[b] = cas_i;
    end else begin : g_ext
      assign status_o[b] = src_sync_i[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_o <= '0;
    else if (mask_we_i) mask_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(status_o & mask_o);
  end
endmodule

// File: rtl/irq_map_group.sv
module irq_map_group #(
  parameter int unsigned W     = 8,
  parameter int unsigned SINKS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     status_i,
  input  logic [SINKS-1:0] mask_we_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     mask_o [SINKS],
  output logic [SINKS-1:0] cas_o
);
  for (genvar k = 0; k < SINKS; k++) begin : g_sink
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           mask_o[k] <= '0;
      else if (mask_we_i[k]) mask_o[k] <= wdata_i;
    end
    assign cas_o[k] = |(status_i & mask_o[k]);
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter int unsigned CAS0_SLOT = 2,
  parameter int unsigned CAS1_SLOT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GRP_W-1:0]  lcl0_src_i,
  input  logic [GRP_W-1:0]  lcl1_src_i,
  input  logic [GRP_W-1:0]  map_src_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [GRP_W-1:0]  bus_wdata_i,
  input  logic              bus_we_i,
  output logic [GRP_W-1:0]  bus_rdata_o,
  output logic              irq0_o,
  output logic              irq1_o
);
  localparam int unsigned NSRC = 3 * GRP_W;

  logic [NSRC-1:0]  src_sync;
  logic [GRP_W-1:0] stat0, stat1, map_stat;
  logic [GRP_W-1:0] mask0, mask1;
  logic [GRP_W-1:0] map_mask [2];
  logic [1:0]       cas;
  logic [1:0]       map_we;
  logic             we0, we1;

  irq_sync #(.W(NSRC), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({map_src_i, lcl1_src_i, lcl0_src_i}),
    .q_o   (src_sync)
  );

  assign map_stat = src_sync[2*GRP_W +: GRP_W];

  assign we0       = bus_we_i && (bus_addr_i == ADR_L0_MASK);
  assign we1       = bus_we_i && (bus_addr_i == ADR_L1_MASK);
  assign map_we[0] = bus_we_i && (bus_addr_i == ADR_MP_MSK0);
  assign map_we[1] = bus_we_i && (bus_addr_i == ADR_MP_MSK1);

  irq_map_group #(.W(GRP_W), .SINKS(2)) u_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (map_stat),
    .mask_we_i(map_we),
    .wdata_i  (bus_wdata_i),
    .mask_o   (map_mask),
    .cas_o    (cas)
  );

  irq_local_group #(.W(GRP_W), .CAS_SLOT(CAS0_SLOT)) u_grp0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_sync_i(src_sync[0 +: GRP_W]),
    .cas_i     (cas[0]),
    .mask_we_i (we0),
    .wdata_i   (bus_wdata_i),
    .status_o  (stat0),
    .mask_o    (mask0),
    .irq_o     (irq0_o)
  );

  irq_local_group #(.W(GRP_W), .CAS_SLOT(CAS1_SLOT)) u_grp1 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_sync_i(src_sync[GRP_W +: GRP_W]),
    .cas_i     (cas[1]),
    .mask_we_i (we1),
    .wdata_i   (bus_wdata_i),
    .status_o  (stat1),
    .mask_o    (mask1),
    .irq_o     (irq1_o)
  );

  always_comb begin
    case (bus_addr_i)
      ADR_L0_STAT: bus_rdata_o = stat0;
      ADR_L0_MASK: bus_rdata_o = mask0;
      ADR_L1_STAT: bus_rdata_o = stat1;
      ADR_L1_MASK: bus_rdata_o = mask1;
      ADR_MP_STAT: bus_rdata_o = map_stat;
      ADR_MP_MSK0: bus_rdata_o = map_mask[0];
      ADR_MP_MSK1: bus_rdata_o = map_mask[1];
      default:     bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk #(
  parameter int unsigned CAS0_SLOT = 2,
  parameter int unsigned CAS1_SLOT = 3
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_we_i,
  input logic [2:0] bus_addr_i,
  input logic [7:0] bus_wdata_i,
  input logic [7:0] bus_rdata_o,
  input logic       irq0_o,
  input logic       irq1_o,
  input logic [7:0] stat0,
  input logic [7:0] stat1,
  input logic [7:0] mask0,
  input logic [7:0] mask1,
  input logic [7:0] map_stat,
  input logic [7:0] map_msk0,
  input logic [7:0] map_msk1
);
  AST_RESET_MASKS: assert property (@(posedge clk_i)
    !rst_ni |-> (mask0 == 8'h00 && mask1 == 8'h00 && map_msk0 == 8'h00 && map_msk1 == 8'h00)); // R1

  AST_IRQ0_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq0_o == $past(|(stat0 & mask0))); // R4

  AST_IRQ1_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq1_o == $past(|(stat1 & mask1))); // R5

  AST_CAS0_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat0[CAS0_SLOT] == |(map_stat & map_msk0)); // R7

  AST_CAS1_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat1[CAS1_SLOT] == |(map_stat & map_msk1)); // R7

  AST_MASK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == 3'd1) |=> mask0 == $past(bus_wdata_i)); // R3

  AST_STAT_WRITE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == 3'd0) |=> ($stable(mask0) && $stable(mask1) && $stable(map_msk0) && $stable(map_msk1))); // R3

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i == 3'd7 |-> bus_rdata_o == 8'h00); // R8
endmodule

bind irq_cascade_ctrl irq_cascade_chk #(.CAS0_SLOT(CAS0_SLOT), .CAS1_SLOT(CAS1_SLOT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .irq0_o     (irq0_o),
  .irq1_o     (irq1_o),
  .stat0      (stat0),
  .stat1      (stat1),
  .mask0      (mask0),
  .mask1      (mask1),
  .map_stat   (map_stat),
  .map_msk0   (map_mask[0]),
  .map_msk1   (map_mask[1])
);

// File: tb/irq_cascade_ctrl_bench.sv
module irq_cascade_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] lcl0_src_i = '0, lcl1_src_i = '0, map_src_i = '0;
  logic [2:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic       bus_we_i = 1'b0;
  logic [7:0] bus_rdata_o;
  logic       irq0_o, irq1_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int         kind;  // 0 read data, 1 irq0, 2 irq1
    logic [7:0] exp;
    string      tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #4 clk_i = ~clk_i;

  irq_cascade_ctrl u_irq_cascade_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lcl0_src_i(lcl0_src_i), .lcl1_src_i(lcl1_src_i), .map_src_i(map_src_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_we_i(bus_we_i),
    .bus_rdata_o(bus_rdata_o), .irq0_o(irq0_o), .irq1_o(irq1_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    sb_item_t it;
    bus_addr_i = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    #3;
  endtask

  task automatic exp_irq(input int which, input logic e, input string tag);
    sb_item_t it;
    it.kind = which; it.exp = {7'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    #3;
  endtask

  // monitor
  initial begin
    forever begin
      sb_item_t it;
      logic [7:0] act;
      wait (sb_q.size() != 0);
      #1;
      it = sb_q.pop_front();
      act = (it.kind == 0) ? bus_rdata_o :
            (it.kind == 1) ? {7'd0, irq0_o} : {7'd0, irq1_o};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    exp_rd(3'd1, 8'h00, "R1 mask0 reset");
    exp_rd(3'd3, 8'h00, "R1 mask1 reset");
    exp_rd(3'd5, 8'h00, "R1 map mask0 reset");
    exp_rd(3'd6, 8'h00, "R1 map mask1 reset");
    exp_irq(1, 1'b0, "R1 irq0 reset");
    exp_irq(2, 1'b0, "R1 irq1 reset");

    // group 0: bit2 replaced by cascade (0)
    lcl0_src_i = 8'hA5;
    step(3);
    exp_rd(3'd0, 8'hA1, "R2 R7 group0 status");
    exp_irq(1, 1'b0, "R4 irq0 all masked");
    wr(3'd1, 8'h10);
    step(2);
    exp_irq(1, 1'b0, "R4 irq0 mask misses");
    wr(3'd1, 8'h01);
    step(2);
    exp_irq(1, 1'b1, "R4 irq0 mask hits");
    exp_rd(3'd1, 8'h01, "R3 mask0 readback");
    wr(3'd0, 8'hFF);
    step(1);
    exp_rd(3'd0, 8'hA1, "R3 status write ignored");
    exp_rd(3'd1, 8'h01, "R3 mask0 untouched");

    // group 1: bit3 replaced by cascade (0)
    lcl1_src_i = 8'h3C;
    step(3);
    exp_rd(3'd2, 8'h34, "R2 R7 group1 status");
    wr(3'd3, 8'h08);
    step(2);
    exp_irq(2, 1'b0, "R5 irq1 cascade slot low");
    exp_rd(3'd3, 8'h08, "R3 mask1 readback");

    // mappable sources
    map_src_i = 8'h81;
    step(3);
    exp_rd(3'd4, 8'h81, "R6 map status unmasked");
    exp_rd(3'd0, 8'hA1, "R7 no cascade with map mask0 zero");
    wr(3'd6, 8'h80);
    step(2);
    exp_rd(3'd2, 8'h3C, "R7 cascade into group1");
    exp_irq(2, 1'b1, "R5 irq1 via cascade");
    exp_rd(3'd6, 8'h80, "R3 map mask1 readback");
    exp_rd(3'd5, 8'h00, "R3 map mask0 independent");
    wr(3'd5, 8'h02);
    step(1);
    exp_rd(3'd0, 8'hA1, "R7 map mask0 no overlap");
    wr(3'd5, 8'h01);
    step(1);
    exp_rd(3'd0, 8'hA5, "R7 cascade into group0");
    wr(3'd4, 8'h00);
    step(1);
    exp_rd(3'd5, 8'h01, "R3 map status write ignored");
    exp_rd(3'd4, 8'h81, "R6 map status after masks");
    exp_rd(3'd7, 8'h00, "R8 unmapped read");

    // release sources
    lcl0_src_i = 8'h00;
    step(3);
    exp_irq(1, 1'b0, "R4 irq0 falls");
    map_src_i = 8'h00;
    step(3);
    exp_irq(2, 1'b0, "R5 irq1 falls");
    exp_rd(3'd2, 8'h34, "R7 group1 cascade cleared");

    step(2);
    wait (sb_q.size() == 0);
    #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule